// File: doc/BRIEF.md
# Second-Order Delta-Sigma Bit-Stream Modulator

This block turns 16-bit audio samples into a one-bit stream clocked at the modulator rate. It takes one sample for every 256 modulator clocks, holds that sample for the whole oversampling period, and passes it through a loop with two integrators and feedback. The loop pushes quantisation noise up in frequency, so the density of ones in the stream follows the input level. The held sample acts as a zero-order hold and takes the place of an interpolation filter.

The block asks for each sample with a one-cycle request pulse. The producer must present the next sample on `sample_i` in the cycle where the pulse is high. A format input selects how that code is read. In offset-binary, code 0x0000 is the lowest level and 0xFFFF is the highest. In two's complement, 0x8000 is the lowest level and 0x7FFF is the highest. A modulator clock of 25.6 MHz gives 100 ksps, which is the top sample rate. Dropping the enable clears the whole loop, and raising it again starts a fresh period.

Top module: `dsm_modulator`

## Requirements
- R1: While reset is applied, and after reset with `enable_i` low, `bit_o` is 0 and `sample_req_o` is 0.
- R2: `sample_req_o` is high in the first cycle in which `enable_i` is high after being low. After that it is high exactly once every 256 clocks, so consecutive requests are 256 cycles apart.
- R3: `sample_i` is captured only in a cycle where `sample_req_o` is high. Values presented in other cycles have no effect on the stream.
- R4: With `fmt_signed_i` = 0, the code is offset-binary, and bit 15 is inverted to form the internal value. Code 0x8000 gives about 50 % ones, 0xC000 about 75 % and 0x4000 about 25 %.
- R5: With `fmt_signed_i` = 1, the code is two's complement and is used unchanged. Code 0x0000 gives about 50 % ones, 0x4000 about 75 % and 0xC000 about 25 %.
- R6: The output bit is 1 when the feedback is +2^15 and 0 when the feedback is −2^15. The count of ones over 16 periods (4096 bits) after one settling period equals 4096·(x+32768)/65536 within ±48, where x is the internal signed value.
- R7: When `enable_i` is low at a clock edge, after that edge `bit_o` is 0, the integrators are cleared and no request is issued. Enabling again restarts the request phase at once.
- R8: Both integrators saturate instead of wrapping. Full-positive input (0xFFFF offset-binary) gives at least 95 % ones. Full-negative input (0x8000 two's complement) gives at most 5 % ones. A midpoint input applied afterwards returns to 50 % within the R6 tolerance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Runs the modulator; low clears the loop and the phase |
| fmt_signed_i | input | 1 | 1 = two's complement input, 0 = offset-binary input |
| sample_i | input | 16 | Sample code, captured in the request cycle |
| sample_req_o | output | 1 | One-cycle pulse marking the capture cycle |
| bit_o | output | 1 | Oversampled one-bit output stream |

## Verification
The assertions check these properties on every cycle:
- request pulses never come back to back;
- the held sample stays stable between requests;
- the held sample matches the format mapping of the code captured at the last request;
- a large positive or negative first integrator cannot change sign in one step, which rules out wrap-around;
- a low enable clears the loop on the next edge.

Only the bench scenarios can show that the density of ones follows the input level for each format. The same holds for these other behaviours:
- values changed between requests leave the stream untouched;
- full-scale input saturates and the loop recovers;
- the request spacing and the phase restart are correct at the ports.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
    localparam int DSM_DATA_W   = 16;
    localparam int DSM_OSR_LOG2 = 8;
    localparam int DSM_GUARD_W  = 6;

    typedef enum logic {
        FMT_OFFSET = 1'b0,
        FMT_TWOS   = 1'b1
    } dsm_fmt_e;
endpackage

// File: rtl/dsm_rate_gen.sv
module dsm_rate_gen #(
    parameter int OSR_LOG2 = dsm_pkg::DSM_OSR_LOG2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic strobe_o
);
    typedef struct packed {
        logic [OSR_LOG2-1:0] phase;
    } rate_st_t;

    rate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) st_d.phase = st_q.phase + OSR_LOG2'(1);
        else      st_d.phase = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe_o = en_i && (st_q.phase == '0);

    // R2
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);
endmodule

// File: rtl/dsm_sample_hold.sv
module dsm_sample_hold #(
    parameter int DATA_W = dsm_pkg::DSM_DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_i,
    input  logic                     strobe_i,
    input  logic                     fmt_i,
    input  logic [DATA_W-1:0]        sample_i,
    output logic signed [DATA_W-1:0] held_o
);
    import dsm_pkg::*;

    localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic signed [DATA_W-1:0] held;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.held = '0;
        end else if (strobe_i) begin
            if (dsm_fmt_e'(fmt_i) == FMT_TWOS)
                st_d.held = sample_i;
            else
                st_d.held = {~sample_i[DATA_W-1], sample_i[DATA_W-2:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_o = st_q.held;

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !strobe_i) |=> $stable(held_o));

    // R4, R5
    fmt_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && strobe_i) |=>
            (held_o == ($past(fmt_i) ? $past(sample_i) : ($past(sample_i) ^ MSB_MASK))));
endmodule

// File: rtl/dsm_loop.sv
module dsm_loop #(
    parameter int DATA_W  = dsm_pkg::DSM_DATA_W,
    parameter int GUARD_W = dsm_pkg::DSM_GUARD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_i,
    input  logic signed [DATA_W-1:0] x_i,
    output logic                     bit_o
);
    localparam int ACC_W = DATA_W + GUARD_W;
    localparam int SUM_W = ACC_W + 2;

    localparam logic signed [SUM_W-1:0] ONE     = SUM_W'(1);
    localparam logic signed [SUM_W-1:0] ACC_MAX = (ONE <<< (ACC_W-1)) - ONE;
    localparam logic signed [SUM_W-1:0] ACC_MIN = -(ONE <<< (ACC_W-1));
    localparam logic signed [SUM_W-1:0] FB_POS  = ONE <<< (DATA_W-1);
    localparam logic signed [SUM_W-1:0] FB_NEG  = -FB_POS;
    localparam logic signed [ACC_W-1:0] STEP    = ACC_W'(1) <<< DATA_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] i1;
        logic signed [ACC_W-1:0] i2;
        logic                    bit_v;
    } loop_st_t;

    loop_st_t st_d, st_q;

    logic signed [SUM_W-1:0] fb;
    logic signed [SUM_W-1:0] sum1, sum2;
    logic signed [ACC_W-1:0] i1_next;

    function automatic logic signed [ACC_W-1:0] clamp(input logic signed [SUM_W-1:0] v);
        logic signed [SUM_W-1:0] r;
        if (v > ACC_MAX)      r = ACC_MAX;
        else if (v < ACC_MIN) r = ACC_MIN;
        else                  r = v;
        return r[ACC_W-1:0];
    endfunction

    always_comb begin
        fb       = st_q.bit_v ? FB_POS : FB_NEG;
        sum1     = SUM_W'(st_q.i1) + SUM_W'(x_i) - fb;
        i1_next  = clamp(sum1);
        sum2     = SUM_W'(st_q.i2) + SUM_W'(i1_next) - fb;
        st_d.i1  = i1_next;
        st_d.i2  = clamp(sum2);
        st_d.bit_v = ~st_d.i2[ACC_W-1];
        if (!en_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o = st_q.bit_v;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q.i1 >= STEP) |=> !st_q.i1[ACC_W-1]);

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q.i1 <= -STEP) |=> st_q.i1[ACC_W-1]);

    // R7
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q.i1 == '0 && st_q.i2 == '0 && !bit_o));
endmodule

// File: rtl/dsm_modulator.sv
module dsm_modulator #(
    parameter int DATA_W   = dsm_pkg::DSM_DATA_W,
    parameter int OSR_LOG2 = dsm_pkg::DSM_OSR_LOG2,
    parameter int GUARD_W  = dsm_pkg::DSM_GUARD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              fmt_signed_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sample_req_o,
    output logic              bit_o
);
    logic                     strobe_w;
    logic signed [DATA_W-1:0] held_w;

    dsm_rate_gen #(.OSR_LOG2(OSR_LOG2)) rate_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (enable_i),
        .strobe_o (strobe_w)
    );

    dsm_sample_hold #(.DATA_W(DATA_W)) hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (enable_i),
        .strobe_i (strobe_w),
        .fmt_i    (fmt_signed_i),
        .sample_i (sample_i),
        .held_o   (held_w)
    );

    dsm_loop #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) loop_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (enable_i),
        .x_i   (held_w),
        .bit_o (bit_o)
    );

    assign sample_req_o = strobe_w;
endmodule

// File: tb/dsm_modulator_tb_top.sv
`timescale 1ns/1ps
module dsm_modulator_tb_top;
    localparam int OSR = 256;
    localparam int WIN = 16 * OSR;
    localparam int TOL = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic        fmt_signed_i = 1'b0;
    logic [15:0] sample_i = 16'h0000;
    logic        sample_req_o;
    logic        bit_o;

    int checks = 0;
    int fails  = 0;
    logic [15:0] junk = 16'h1357;

    typedef struct {
        int    exp_ones;
        int    mode;
        string req;
    } exp_t;

    exp_t exp_q[$];
    bit   mon_done = 1'b0;

    always #10 clk = ~clk;

    dsm_modulator dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .fmt_signed_i (fmt_signed_i),
        .sample_i     (sample_i),
        .sample_req_o (sample_req_o),
        .bit_o        (bit_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Monitor: pops one expectation, skips two requests to settle, counts ones
    initial begin
        forever begin
            exp_t it;
            int   ones;
            wait (exp_q.size() > 0);
            it = exp_q.pop_front();
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                while (!sample_req_o) @(negedge clk);
            end
            ones = 0;
            for (int c = 0; c < WIN; c++) begin
                @(negedge clk);
                ones += int'(bit_o);
            end
            case (it.mode)
                0: check((ones >= it.exp_ones - TOL) && (ones <= it.exp_ones + TOL),
                         it.req, "ones density", ones, it.exp_ones);
                1: check(ones >= it.exp_ones, it.req, "ones at least", ones, it.exp_ones);
                default: check(ones <= it.exp_ones, it.req, "ones at most", ones, it.exp_ones);
            endcase
            mon_done = 1'b1;
        end
    end

    // Driver: applies a level, pushes its expected ones count, optionally
    // scrambles sample_i outside request cycles
    task automatic apply_level(input bit f, input logic [15:0] v, input int mode,
                               input string req, input bit jit);
        exp_t it;
        int   x;
        @(negedge clk);
        fmt_signed_i = f;
        sample_i     = v;
        x = f ? int'($signed(v)) : int'(v) - 32768;
        it.mode = mode;
        it.req  = req;
        if (mode == 1)      it.exp_ones = WIN * 95 / 100;
        else if (mode == 2) it.exp_ones = WIN * 5 / 100;
        else                it.exp_ones = ((x + 32768) * WIN) / 65536;
        mon_done = 1'b0;
        exp_q.push_back(it);
        if (jit) begin
            while (!mon_done) begin
                @(negedge clk);
                if (sample_req_o) sample_i = v;
                else begin
                    junk = junk + 16'h3A5B;
                    sample_i = junk;
                end
            end
            sample_i = v;
        end else begin
            wait (mon_done);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int gap;
        int ones;
        // R1 reset state
        repeat (4) @(negedge clk);
        check(bit_o == 1'b0, "R1", "bit_o in reset", int'(bit_o), 0);
        check(sample_req_o == 1'b0, "R1", "request in reset", int'(sample_req_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(bit_o == 1'b0 && sample_req_o == 1'b0, "R1", "idle after reset",
              int'(bit_o) + int'(sample_req_o), 0);

        // R2 first request and spacing
        fmt_signed_i = 1'b0;
        sample_i     = 16'h8000;
        enable_i     = 1'b1;
        #1;
        check(sample_req_o == 1'b1, "R2", "request on enable", int'(sample_req_o), 1);
        for (int k = 0; k < 2; k++) begin
            gap = 0;
            do begin
                @(negedge clk);
                gap++;
            end while (!sample_req_o);
            check(gap == OSR, "R2", "request spacing", gap, OSR);
        end

        // R4 offset-binary levels
        apply_level(1'b0, 16'h8000, 0, "R4", 1'b0);
        apply_level(1'b0, 16'hC000, 0, "R4", 1'b0);
        apply_level(1'b0, 16'h4000, 0, "R4", 1'b0);
        // R5 two's complement levels
        apply_level(1'b1, 16'h0000, 0, "R5", 1'b0);
        apply_level(1'b1, 16'h4000, 0, "R5", 1'b0);
        apply_level(1'b1, 16'hC000, 0, "R5", 1'b0);
        // R6 further levels
        apply_level(1'b1, 16'h2000, 0, "R6", 1'b0);
        apply_level(1'b0, 16'h3000, 0, "R6", 1'b0);
        // R3 scrambled input between requests
        apply_level(1'b1, 16'hE000, 0, "R3", 1'b1);
        // R8 full scale and recovery
        apply_level(1'b0, 16'hFFFF, 1, "R8", 1'b0);
        apply_level(1'b1, 16'h8000, 2, "R8", 1'b0);
        apply_level(1'b1, 16'h0000, 0, "R8", 1'b0);

        // R7 disable clears the loop
        @(negedge clk);
        while (!bit_o) @(negedge clk);
        enable_i = 1'b0;
        #1;
        check(sample_req_o == 1'b0, "R7", "no request when disabled", int'(sample_req_o), 0);
        @(negedge clk);
        check(bit_o == 1'b0, "R7", "bit cleared after disable", int'(bit_o), 0);
        ones = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            ones += int'(bit_o) + int'(sample_req_o);
        end
        check(ones == 0, "R7", "quiet while disabled", ones, 0);
        enable_i = 1'b1;
        #1;
        check(sample_req_o == 1'b1, "R7", "phase restart on enable", int'(sample_req_o), 1);
        apply_level(1'b0, 16'h8000, 0, "R7", 1'b0);

        summary();
        $finish;
    end
endmodule